// File: doc/BRIEF.md
# Round-Robin Shared Bus Interconnect

This block joins a set of bus masters to a set of memory-mapped servants over one shared bus. When several masters ask for the bus at once, a round-robin arbiter picks one. The bus then copies that master's request (address, direction and burst length) to every servant for a fixed request phase. The bus does not decode addresses. Each servant decides for itself whether the address is its own. The servant that claims it pulses an acknowledge, and the bus passes that acknowledge back to the granted master only. If no servant answers inside a fixed listening window, the granted master gets a one-cycle error pulse instead.

After the acknowledge, the bus moves the data one word per beat. A write beat takes one cycle: the granted master's word goes out to the servants, and the master gets a strobe telling it to present the next word. A read beat takes two cycles. The first cycle strobes the servants. In the second cycle the bus returns the word from the servant that acknowledged. A burst holds the grant until its last beat ends. Masters see only request, acknowledge, error and data; the arbitration order is hidden from them.

Top module: `rr_shared_bus`

## Requirements
- R1: Arbitration is round-robin. After reset, master 0 has first priority. After each grant, priority starts at the master after the one just granted, so a master with a pending request is never passed over twice in a row.
- R2: Once a master is granted, `s_req` is high for exactly REQ_CYC (2) cycles. During those cycles `s_addr`, `s_write` and `s_blen` hold the granted master's values.
- R3: An acknowledge arriving on any `s_ack` bit during the listening window causes exactly one one-cycle pulse on the granted master's `m_ack` bit, in the cycle after it is sampled. No other master's `m_ack` bit is set.
- R4: `s_ack` is ignored outside the listening window, whether the bus is idle or in the request phase. An acknowledge given only in the request phase does not count, so the transfer ends in an error.
- R5: If no acknowledge arrives during the TIMEOUT (4) listening cycles, the granted master alone receives a one-cycle `m_err` pulse. No data beat follows, and the bus goes back to idle.
- R6: The burst length field holds the beat count minus one (0 means a single word, 15 means 16 words). A write moves exactly that many beats, one per cycle. Each beat raises `s_wvalid`, places the granted master's `m_wdata` word on `s_wdata`, and pulses that master's `m_wtake` bit.
- R7: A read moves exactly the coded number of beats, two cycles each. The first cycle raises `s_rstrobe`. The second raises the granted master's `m_rvalid` bit, with `m_rdata` equal to the `s_rdata` word of the servant that acknowledged.
- R8: The grant is held until the last beat or the error pulse. A second master that keeps requesting gets no acknowledge, error or data strobe in that time, and is served afterwards.
- R9: During and right after reset, every strobe and every output to the masters is zero, and the arbiter priority starts at master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | NM | One request line per master, held until acknowledge or error |
| m_write | input | NM | Direction per master, 1 = write |
| m_addr | input | NM*AW | Address per master, master i in slice i |
| m_blen | input | NM*BLW | Burst beats minus one per master |
| m_wdata | input | NM*DW | Current write word per master |
| m_ack | output | NM | Forwarded acknowledge pulse, per master |
| m_err | output | NM | No-servant error pulse, per master |
| m_wtake | output | NM | Write word consumed, per master |
| m_rvalid | output | NM | Read word valid, per master |
| m_rdata | output | DW | Read word returned to the granted master |
| s_req | output | 1 | Request phase strobe broadcast to servants |
| s_addr | output | AW | Broadcast address of the granted request |
| s_write | output | 1 | Broadcast direction |
| s_blen | output | BLW | Broadcast burst length field |
| s_wvalid | output | 1 | Write beat strobe |
| s_wdata | output | DW | Write word for the current beat |
| s_rstrobe | output | 1 | First cycle of a read beat |
| s_ack | input | NS | Acknowledge from each servant |
| s_rdata | input | NS*DW | Read word from each servant, servant j in slice j |

## Verification
The bench goes after the edges of the listening window. It acknowledges as early and as late as the window allows, and it acknowledges only during the request phase. A window that is off by one cycle either drops a late acknowledge and raises a false error, or counts an acknowledge given during the request phase. Unmapped addresses must give an error pulse to the requester alone, with no data beats after it. A bus that keeps going into data would show a stray write or read strobe. Both masters request together to test the rotation of priority and the holding of the grant. An arbiter that does not rotate would serve the same master twice, and a bus that releases the grant early would send the other master's words or acknowledge mid-burst. Bursts of 1, 2, 4, 8 and 16 beats check the beat counts and the read data routing from each servant.

// File: rtl/rr_bus_pkg.sv
package rr_bus_pkg;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_REQ,
    BS_LISTEN,
    BS_ACK,
    BS_ERR,
    BS_WBEAT,
    BS_RSTROBE,
    BS_RRET
  } bus_state_e;

  // A beat counter has reached the final beat when it equals the coded length.
  function automatic logic beat_is_last(input logic [7:0] cnt, input logic [7:0] blen_code);
    return cnt == blen_code;
  endfunction

endpackage

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter #(
  parameter int NM = 2,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req,
  input  logic          take,
  output logic [IW-1:0] gnt_idx,
  output logic          any_req
);

  logic [IW-1:0] last_gnt;

  // Scans from the master after last; last itself is the lowest priority.
  function automatic logic [IW-1:0] rr_pick(input logic [NM-1:0] r, input logic [IW-1:0] last);
    logic [IW-1:0] pick;
    int idx;
    pick = last;
    for (int off = NM; off >= 1; off--) begin
      idx = int'(last) + off;
      if (idx >= NM) idx = idx - NM;
      if (r[idx]) pick = IW'(idx);
    end
    return pick;
  endfunction

  assign any_req = |req;
  assign gnt_idx = rr_pick(req, last_gnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_gnt <= IW'(NM - 1);
    else if (take) last_gnt <= gnt_idx;
  end

  AST_GNT_IS_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> req[gnt_idx]); // R1
  AST_RR_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ($countones(req) > 1)) |-> (gnt_idx != last_gnt)); // R1

endmodule

// File: rtl/rr_bus_ctl.sv
module rr_bus_ctl
  import rr_bus_pkg::*;
#(
  parameter int BLW     = 4,
  parameter int REQ_CYC = 2,
  parameter int TIMEOUT = 4,
  localparam int TMAX = (REQ_CYC > TIMEOUT) ? REQ_CYC : TIMEOUT,
  localparam int TW   = $clog2(TMAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any_req,
  input  logic           any_ack,
  input  logic           lat_write,
  input  logic [BLW-1:0] lat_blen,
  output logic           take,
  output logic           busy,
  output logic           req_ph,
  output logic           ack_cap,
  output logic           ack_ph,
  output logic           err_ph,
  output logic           wr_beat,
  output logic           rd_strobe,
  output logic           rd_beat
);

  bus_state_e st, st_nx;
  logic [TW-1:0]  tcnt, tcnt_nx;
  logic [BLW-1:0] bcnt, bcnt_nx;
  logic last_beat;

  assign last_beat = beat_is_last(8'(bcnt), 8'(lat_blen));

  always_comb begin
    st_nx   = st;
    tcnt_nx = tcnt;
    bcnt_nx = bcnt;
    unique case (st)
      BS_IDLE: if (any_req) begin
        st_nx   = BS_REQ;
        tcnt_nx = '0;
      end
      BS_REQ: begin
        if (tcnt == TW'(REQ_CYC - 1)) begin
          st_nx   = BS_LISTEN;
          tcnt_nx = '0;
        end else tcnt_nx = tcnt + 1'b1;
      end
      BS_LISTEN: begin
        if (any_ack) st_nx = BS_ACK;
        else if (tcnt == TW'(TIMEOUT - 1)) st_nx = BS_ERR;
        else tcnt_nx = tcnt + 1'b1;
      end
      BS_ACK: begin
        bcnt_nx = '0;
        st_nx   = lat_write ? BS_WBEAT : BS_RSTROBE;
      end
      BS_ERR: st_nx = BS_IDLE;
      BS_WBEAT: begin
        if (last_beat) st_nx = BS_IDLE;
        else bcnt_nx = bcnt + 1'b1;
      end
      BS_RSTROBE: st_nx = BS_RRET;
      BS_RRET: begin
        if (last_beat) st_nx = BS_IDLE;
        else begin
          bcnt_nx = bcnt + 1'b1;
          st_nx   = BS_RSTROBE;
        end
      end
      default: st_nx = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= BS_IDLE;
      tcnt <= '0;
      bcnt <= '0;
    end else begin
      st   <= st_nx;
      tcnt <= tcnt_nx;
      bcnt <= bcnt_nx;
    end
  end

  assign take      = (st == BS_IDLE) && any_req;
  assign busy      = (st != BS_IDLE);
  assign req_ph    = (st == BS_REQ);
  assign ack_cap   = (st == BS_LISTEN) && any_ack;
  assign ack_ph    = (st == BS_ACK);
  assign err_ph    = (st == BS_ERR);
  assign wr_beat   = (st == BS_WBEAT);
  assign rd_strobe = (st == BS_RSTROBE);
  assign rd_beat   = (st == BS_RRET);

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ph, ack_ph, err_ph, wr_beat, rd_strobe, rd_beat})); // R2
  AST_REQ_TWO_PLUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ph) |=> req_ph); // R2
  AST_ACK_FOLLOWS_SERVANT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ph |-> $past(any_ack)); // R3
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ph |=> !ack_ph); // R3
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    err_ph |=> (!err_ph && !wr_beat && !rd_strobe && !rd_beat)); // R5
  AST_RD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> rd_beat); // R7

endmodule

// File: rtl/rr_bus_route.sv
module rr_bus_route #(
  parameter int NM  = 2,
  parameter int NS  = 2,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BLW = 4,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             busy,
  input  logic [IW-1:0]    gnt_idx,
  input  logic [NM-1:0]    m_write,
  input  logic [NM*AW-1:0] m_addr,
  input  logic [NM*BLW-1:0] m_blen,
  input  logic [NM*DW-1:0] m_wdata,
  input  logic             ack_cap,
  input  logic [NS-1:0]    s_ack,
  input  logic [NS*DW-1:0] s_rdata,
  input  logic             ack_ph,
  input  logic             err_ph,
  input  logic             wr_beat,
  input  logic             rd_beat,
  output logic             lat_write,
  output logic [BLW-1:0]   lat_blen,
  output logic [AW-1:0]    lat_addr,
  output logic [DW-1:0]    s_wdata,
  output logic [DW-1:0]    m_rdata,
  output logic [NM-1:0]    m_ack,
  output logic [NM-1:0]    m_err,
  output logic [NM-1:0]    m_wtake,
  output logic [NM-1:0]    m_rvalid
);

  logic [IW-1:0] gnt_q;
  logic [SW-1:0] sidx_q;

  function automatic logic [SW-1:0] first_ack(input logic [NS-1:0] a);
    logic [SW-1:0] r;
    r = '0;
    for (int j = NS - 1; j >= 0; j--) if (a[j]) r = SW'(j);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q     <= '0;
      lat_write <= 1'b0;
      lat_blen  <= '0;
      lat_addr  <= '0;
      sidx_q    <= '0;
    end else begin
      if (take) begin
        gnt_q     <= gnt_idx;
        lat_write <= m_write[gnt_idx];
        lat_blen  <= m_blen[gnt_idx*BLW +: BLW];
        lat_addr  <= m_addr[gnt_idx*AW +: AW];
      end
      if (ack_cap) sidx_q <= first_ack(s_ack);
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_mout
    assign m_ack[i]    = ack_ph  && (gnt_q == IW'(i));
    assign m_err[i]    = err_ph  && (gnt_q == IW'(i));
    assign m_wtake[i]  = wr_beat && (gnt_q == IW'(i));
    assign m_rvalid[i] = rd_beat && (gnt_q == IW'(i));
  end

  assign s_wdata = wr_beat ? m_wdata[gnt_q*DW +: DW] : '0;
  assign m_rdata = rd_beat ? s_rdata[sidx_q*DW +: DW] : '0;

  AST_ACK_ONE_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_ack | m_err)); // R3
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(gnt_q)); // R8
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (|m_err) |-> (m_wtake == '0 && m_rvalid == '0)); // R5

endmodule

// File: rtl/rr_shared_bus.sv
module rr_shared_bus #(
  parameter int NM      = 2,
  parameter int NS      = 2,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int BLW     = 4,
  parameter int REQ_CYC = 2,
  parameter int TIMEOUT = 4,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NM-1:0]     m_req,
  input  logic [NM-1:0]     m_write,
  input  logic [NM*AW-1:0]  m_addr,
  input  logic [NM*BLW-1:0] m_blen,
  input  logic [NM*DW-1:0]  m_wdata,
  output logic [NM-1:0]     m_ack,
  output logic [NM-1:0]     m_err,
  output logic [NM-1:0]     m_wtake,
  output logic [NM-1:0]     m_rvalid,
  output logic [DW-1:0]     m_rdata,
  output logic              s_req,
  output logic [AW-1:0]     s_addr,
  output logic              s_write,
  output logic [BLW-1:0]    s_blen,
  output logic              s_wvalid,
  output logic [DW-1:0]     s_wdata,
  output logic              s_rstrobe,
  input  logic [NS-1:0]     s_ack,
  input  logic [NS*DW-1:0]  s_rdata
);

  logic [IW-1:0]  gnt_idx;
  logic           any_req, take, busy, req_ph, ack_cap, ack_ph, err_ph;
  logic           wr_beat, rd_strobe, rd_beat, lat_write;
  logic [BLW-1:0] lat_blen;
  logic [AW-1:0]  lat_addr;

  rr_bus_arbiter #(.NM(NM)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(m_req), .take(take),
    .gnt_idx(gnt_idx), .any_req(any_req)
  );

  rr_bus_ctl #(.BLW(BLW), .REQ_CYC(REQ_CYC), .TIMEOUT(TIMEOUT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .any_req(any_req), .any_ack(|s_ack),
    .lat_write(lat_write), .lat_blen(lat_blen),
    .take(take), .busy(busy), .req_ph(req_ph), .ack_cap(ack_cap),
    .ack_ph(ack_ph), .err_ph(err_ph), .wr_beat(wr_beat),
    .rd_strobe(rd_strobe), .rd_beat(rd_beat)
  );

  rr_bus_route #(.NM(NM), .NS(NS), .AW(AW), .DW(DW), .BLW(BLW)) u_route (
    .clk(clk), .rst_n(rst_n), .take(take), .busy(busy), .gnt_idx(gnt_idx),
    .m_write(m_write), .m_addr(m_addr), .m_blen(m_blen), .m_wdata(m_wdata),
    .ack_cap(ack_cap), .s_ack(s_ack), .s_rdata(s_rdata),
    .ack_ph(ack_ph), .err_ph(err_ph), .wr_beat(wr_beat), .rd_beat(rd_beat),
    .lat_write(lat_write), .lat_blen(lat_blen), .lat_addr(lat_addr),
    .s_wdata(s_wdata), .m_rdata(m_rdata),
    .m_ack(m_ack), .m_err(m_err), .m_wtake(m_wtake), .m_rvalid(m_rvalid)
  );

  assign s_req     = req_ph;
  assign s_addr    = lat_addr;
  assign s_write   = lat_write;
  assign s_blen    = lat_blen;
  assign s_wvalid  = wr_beat;
  assign s_rstrobe = rd_strobe;

  AST_WRITE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    s_wvalid |-> s_write); // R6
  AST_READ_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rstrobe || (|m_rvalid)) |-> !s_write); // R7
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req && $past(s_req)) |-> ($stable(s_addr) && $stable(s_blen))); // R2

endmodule

// File: tb/rr_shared_bus_test.sv
`timescale 1ns/1ps
module rr_shared_bus_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  m_req, m_write, m_ack, m_err, m_wtake, m_rvalid;
  logic [63:0] m_addr, m_wdata, s_rdata;
  logic [7:0]  m_blen;
  logic [31:0] m_rdata, s_addr, s_wdata;
  logic        s_req, s_write, s_wvalid, s_rstrobe;
  logic [3:0]  s_blen;
  logic [1:0]  s_ack;

  logic [31:0] b_addr [2];
  logic        b_wr   [2];
  logic [3:0]  b_blen [2];
  logic [31:0] b_wd   [2];
  logic [1:0]  b_req;

  always_comb begin
    m_req   = b_req;
    m_write = {b_wr[1], b_wr[0]};
    m_addr  = {b_addr[1], b_addr[0]};
    m_blen  = {b_blen[1], b_blen[0]};
    m_wdata = {b_wd[1], b_wd[0]};
  end

  rr_shared_bus uut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_write(m_write), .m_addr(m_addr),
    .m_blen(m_blen), .m_wdata(m_wdata), .m_ack(m_ack), .m_err(m_err),
    .m_wtake(m_wtake), .m_rvalid(m_rvalid), .m_rdata(m_rdata), .s_req(s_req),
    .s_addr(s_addr), .s_write(s_write), .s_blen(s_blen), .s_wvalid(s_wvalid),
    .s_wdata(s_wdata), .s_rstrobe(s_rstrobe), .s_ack(s_ack), .s_rdata(s_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wword(input int g, input int i);
    return 32'h5A00_0000 + 32'(g) * 32'h0010_0000 + 32'(i) * 32'h11 + 32'h7;
  endfunction

  function automatic logic [31:0] rword(input int k, input logic [31:0] a, input int i);
    return (32'hA000_0000 + 32'(k) * 32'h0100_0000) ^ (a + 32'(i));
  endfunction

  typedef struct packed {
    logic        m;
    logic [31:0] addr;
    logic        wr;
    logic [3:0]  blen;
    logic [1:0]  dly;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 32'h0000_0010, 1'b1, 4'd0,  2'd0},
    '{1'b1, 32'h1000_0020, 1'b0, 4'd0,  2'd1},
    '{1'b0, 32'h1000_0100, 1'b1, 4'd3,  2'd2},
    '{1'b1, 32'h0000_0200, 1'b0, 4'd3,  2'd3},
    '{1'b0, 32'h2000_0000, 1'b0, 4'd1,  2'd0},
    '{1'b1, 32'h0000_0300, 1'b1, 4'd15, 2'd0},
    '{1'b1, 32'hF000_0000, 1'b1, 4'd0,  2'd2},
    '{1'b0, 32'h1000_0400, 1'b0, 4'd7,  2'd1}
  };

  task automatic setm(input int m, input logic [31:0] a, input logic wr, input logic [3:0] bl);
    b_addr[m] = a; b_wr[m] = wr; b_blen[m] = bl; b_wd[m] = wword(m, 0);
    b_req[m] = 1'b1;
  endtask

  // Runs one transfer of expected winner g; servant k answers addresses with top nibble k.
  task automatic do_txn(input int g, input int dly, input bit early);
    int sv;
    bit mapped;
    int waitn;
    sv = int'(b_addr[g][31:28]);
    mapped = (sv < 2) && !early;
    waitn = 0;
    while (s_req !== 1'b1 && waitn < 12) begin @(negedge clk); waitn++; end
    chk("R2 request seen", 64'(s_req), 64'd1);
    chk("R2 addr", 64'(s_addr), 64'(b_addr[g]));
    chk("R2 dir", 64'(s_write), 64'(b_wr[g]));
    chk("R2 blen", 64'(s_blen), 64'(b_blen[g]));
    if (early && sv < 2) s_ack[sv] = 1'b1;
    @(negedge clk);
    chk("R2 second request cycle", 64'(s_req), 64'd1);
    @(negedge clk);
    s_ack = 2'b00;
    chk("R2 request ends after two", 64'(s_req), 64'd0);
    if (mapped) begin
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk("R3 no ack before servant", 64'(m_ack), 64'd0);
      end
      s_ack[sv] = 1'b1;
      @(negedge clk);
      s_ack = 2'b00;
      chk("R3 ack to winner", 64'(m_ack), 64'(2'b01 << g));
      chk("R3 no error", 64'(m_err), 64'd0);
      b_req[g] = 1'b0;
      for (int i = 0; i <= int'(b_blen[g]); i++) begin
        if (b_wr[g]) begin
          @(negedge clk);
          chk("R6 write strobe", 64'(s_wvalid), 64'd1);
          chk("R6 write word", 64'(s_wdata), 64'(wword(g, i)));
          chk("R8 take only winner", 64'(m_wtake), 64'(2'b01 << g));
          b_wd[g] = wword(g, i + 1);
        end else begin
          @(negedge clk);
          chk("R7 read strobe", 64'(s_rstrobe), 64'd1);
          chk("R7 no data in strobe cycle", 64'(m_rvalid), 64'd0);
          s_rdata = {rword(1, b_addr[g], i), rword(0, b_addr[g], i)};
          @(negedge clk);
          chk("R7 rvalid winner", 64'(m_rvalid), 64'(2'b01 << g));
          chk("R7 read word", 64'(m_rdata), 64'(rword(sv, b_addr[g], i)));
        end
        chk("R8 other master quiet", 64'(m_ack | m_err), 64'd0);
      end
      @(negedge clk);
      chk("R6 R7 beats end", 64'({s_wvalid, s_rstrobe, m_rvalid}), 64'd0);
    end else begin
      for (int w = 0; w < 4; w++) begin
        chk("R5 no error in window", 64'(m_err | m_ack), 64'd0);
        @(negedge clk);
      end
      chk("R5 error to requester", 64'(m_err), 64'(2'b01 << g));
      chk("R4 R5 no ack", 64'(m_ack), 64'd0);
      b_req[g] = 1'b0;
      @(negedge clk);
      chk("R5 no data after error", 64'({m_err, s_wvalid, s_rstrobe}), 64'd0);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    b_req = 2'b00; s_ack = 2'b00; s_rdata = '0;
    for (int m = 0; m < 2; m++) begin
      b_addr[m] = '0; b_wr[m] = 1'b0; b_blen[m] = '0; b_wd[m] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", 64'({m_ack, m_err, m_wtake, m_rvalid, s_req, s_wvalid, s_rstrobe}), 64'd0);
    chk("R9 reset addr", 64'(s_addr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", 64'({m_ack, m_err, s_req}), 64'd0);

    // R4: acks while idle are ignored
    s_ack = 2'b11;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R4 idle ack ignored", 64'({m_ack, m_err, s_req}), 64'd0);
    end
    s_ack = 2'b00;
    @(negedge clk);
    chk("R4 no late ack", 64'(m_ack), 64'd0);

    // R1 R9: both request after reset, master 0 goes first, master 1 held (R8)
    setm(0, 32'h0000_0040, 1'b1, 4'd1);
    setm(1, 32'h1000_0050, 1'b0, 4'd1);
    do_txn(0, 0, 1'b0);
    do_txn(1, 3, 1'b0);

    // Vector table walk
    for (int v = 0; v < 8; v++) begin
      setm(int'(VEC[v].m), VEC[v].addr, VEC[v].wr, VEC[v].blen);
      do_txn(int'(VEC[v].m), int'(VEC[v].dly), 1'b0);
    end

    // R1: last grant was master 0, so master 1 wins a tie; then master 0 again wins
    setm(0, 32'h0000_0070, 1'b0, 4'd0);
    setm(1, 32'h0000_0080, 1'b1, 4'd2);
    do_txn(1, 1, 1'b0);
    setm(1, 32'h1000_0090, 1'b1, 4'd0);
    do_txn(0, 0, 1'b0);
    do_txn(1, 2, 1'b0);

    // R4: ack given only during request phase does not count -> error
    setm(0, 32'h0000_00A0, 1'b1, 4'd0);
    do_txn(0, 0, 1'b1);

    // R9: reset mid-transfer clears outputs and priority
    setm(1, 32'h0000_00B0, 1'b1, 4'd3);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    b_req = 2'b00;
    @(negedge clk);
    chk("R9 reset mid transfer", 64'({m_ack, m_err, m_wtake, s_req, s_wvalid}), 64'd0);
    rst_n = 1'b1;
    setm(0, 32'h1000_00C0, 1'b0, 4'd0);
    setm(1, 32'h0000_00D0, 1'b1, 4'd0);
    do_txn(0, 0, 1'b0);
    do_txn(1, 0, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule